// File: doc/BRIEF.md
# Cascadable 32-bit Event Capture Timer

This block pairs two identical 16-bit counting slices into one 32-bit counter. The low slice advances on a tick source chosen from three options: every clock, an external count strobe, or an event line. The high slice counts the one-cycle overflow pulses that the low slice emits each time it wraps. A single capture event goes to both slices, and each slice copies its count into its own capture register. The two capture registers, high above low, form one 32-bit timestamp.

Each slice has a cascade control. On a slice with cascade set, the capture lands one clock after the capture event instead of on the same edge. This delay matches the one-cycle lag between a low-half wrap and the resulting high-half increment. With the low slice's cascade clear and the high slice's cascade set, a capture that coincides with a low-half wrap still gives a self-consistent 32-bit value. Each slice also has an enable that freezes it.

Top module: `cap_timer32`

## Requirements
- R1: A low `rst_n` sampled at a clock edge clears both counts, both capture halves and both overflow outputs to zero at that edge.
- R2: With `src_sel` = 0 and the low slice enabled, `cnt_lo` advances by one at every clock edge.
- R3: When the low count advances from all ones, it becomes zero, and `ovf_lo` is high for exactly the one cycle that follows that edge.
- R4: With `src_sel` = 1 the low slice advances only at edges where `cnt_strobe` is high. With `src_sel` = 2 it advances only at edges where `cnt_event` is high. With `src_sel` = 3 it never advances. The line that is not selected has no effect.
- R5: The high count advances by one at the clock edge that follows each edge at which `ovf_lo` is high, provided the high slice is enabled.
- R6: With `casc_lo` = 0, a `capt_evt` sampled at an edge loads `cap_value[15:0]` with the low count held just before that edge. If a tick arrives at the same edge, the capture keeps the pre-increment value and the count still increments.
- R7: With `casc_lo` = 0 and `casc_hi` = 1, the high half is captured one clock after the capture event. Once both halves have settled, `cap_value` equals the number of low ticks completed before the capture edge, modulo 2^32, including captures that land on a low-half wrap.
- R8: While a slice's enable is low, its count holds, it emits no overflow pulse, and a capture event leaves its capture half unchanged.
- R9: With `casc_hi` = 0, the high half is captured at the same edge as the capture event, so it holds the high count from before that edge.
- R10: `ovf_hi` is high for the one cycle that follows an edge at which the high count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the tick for source 0 |
| rst_n | input | 1 | Synchronous active-low reset |
| en_lo | input | 1 | Low slice enable |
| en_hi | input | 1 | High slice enable |
| casc_lo | input | 1 | Low slice cascade (delayed capture) control |
| casc_hi | input | 1 | High slice cascade (delayed capture) control |
| src_sel | input | 2 | Low slice tick source: 0 clock, 1 strobe, 2 event, 3 none |
| cnt_strobe | input | 1 | External count strobe |
| cnt_event | input | 1 | Count event line |
| capt_evt | input | 1 | Shared capture event |
| cnt_lo | output | 16 | Live low count |
| cnt_hi | output | 16 | Live high count |
| ovf_lo | output | 1 | Low slice overflow pulse |
| ovf_hi | output | 1 | High slice overflow pulse |
| cap_value | output | 32 | Captured value, high half in bits 31:16 |

## Verification
Live counts and overflow pulses appear one edge after the tick that causes them. The high count trails a low-half wrap by a second edge. A capture fills the low half at the event's own edge and the cascaded high half one edge later. The bench therefore compares `cap_value` only at the falling edge after the second rising edge that follows the event, and it holds the capture input low during that cycle. Its model counts low ticks arithmetically and derives every expected value from that total and its one-edge and two-edge history. The sweep is run on a 4-bit slice width, so the combined counter wraps within a few hundred cycles and every low-half phase meets a capture.

// File: rtl/cap_timer_pkg.sv
// Shared types for the cascadable capture timer.
// Assumes: a tick source is encoded in two bits; code 3 selects no source.
package cap_timer_pkg;
    typedef enum logic [1:0] {
        SRC_PCLK   = 2'd0,
        SRC_STROBE = 2'd1,
        SRC_EVENT  = 2'd2,
        SRC_NONE   = 2'd3
    } tick_src_e;
endpackage

// File: rtl/cap_tick_sel.sv
// Selects the tick that advances one slice's counter.
// Assumes: strobe and event inputs are already synchronous to clk.
module cap_tick_sel
    import cap_timer_pkg::*;
(
    input  tick_src_e sel,
    input  logic      strobe,
    input  logic      event_in,
    output logic      tick
);
    // Route the chosen source to the tick line.
    always_comb begin
        case (sel)
            SRC_PCLK:   tick = 1'b1;
            SRC_STROBE: tick = strobe;
            SRC_EVENT:  tick = event_in;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_counter.sv
// Wrapping up-counter with a registered one-cycle overflow pulse.
// Assumes: tick is qualified by en here; reset is synchronous, active low.
module cap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic step;

    // A count step needs both the enable and a tick.
    always_comb step = en & tick;

    // Advance the count, wrap at all ones, and flag the wrap for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= step & (count == CNT_MAX);
            if (step) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cap_capture.sv
// Capture register for one slice, with an optional one-clock delay.
// Assumes: count is the slice's registered count; with cascade set the
// capture takes the count one edge after the event edge.
module cap_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cascade,
    input  logic         capt,
    input  logic [W-1:0] count,
    output logic [W-1:0] cap
);
    logic capt_d;
    logic fire;

    // Choose the immediate or delayed event, qualified by the enable.
    always_comb fire = en & (cascade ? capt_d : capt);

    // Hold the delayed event and load the capture register when it fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capt_d <= 1'b0;
            cap    <= '0;
        end else begin
            capt_d <= en & capt;
            if (fire) begin
                cap <= count;
            end
        end
    end
endmodule

// File: rtl/cap_slice.sv
// One timer slice: tick selection, wrapping counter, capture register.
// Assumes: sel is static while counting; capt is a one-cycle pulse.
module cap_slice
    import cap_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cascade,
    input  tick_src_e    sel,
    input  logic         strobe,
    input  logic         event_in,
    input  logic         capt,
    output logic [W-1:0] count,
    output logic [W-1:0] cap,
    output logic         ovf
);
    logic tick;

    cap_tick_sel u_sel (
        .sel      (sel),
        .strobe   (strobe),
        .event_in (event_in),
        .tick     (tick)
    );

    cap_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .count (count),
        .ovf   (ovf)
    );

    cap_capture #(.W(W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cascade (cascade),
        .capt    (capt),
        .count   (count),
        .cap     (cap)
    );
endmodule

// File: rtl/cap_timer32.sv
// Two cascaded slices forming a double-width capture counter.
// Slice 0 counts the selected source; each later slice counts the
// overflow pulses of the slice below it. One capture event feeds all.
// Assumes: casc_lo = 0 and casc_hi = 1 for a consistent captured value.
module cap_timer32
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_lo,
    input  logic               en_hi,
    input  logic               casc_lo,
    input  logic               casc_hi,
    input  logic [1:0]         src_sel,
    input  logic               cnt_strobe,
    input  logic               cnt_event,
    input  logic               capt_evt,
    output logic [CNT_W-1:0]   cnt_lo,
    output logic [CNT_W-1:0]   cnt_hi,
    output logic               ovf_lo,
    output logic               ovf_hi,
    output logic [2*CNT_W-1:0] cap_value
);
    localparam int NSLICE = 2;

    logic [NSLICE-1:0] en_v;
    logic [NSLICE-1:0] casc_v;
    logic [NSLICE-1:0] ovf_v;
    logic [CNT_W-1:0]  cnt_v [NSLICE];
    logic [CNT_W-1:0]  cap_v [NSLICE];

    assign en_v   = {en_hi, en_lo};
    assign casc_v = {casc_hi, casc_lo};

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        if (g == 0) begin : g_base
            cap_slice #(.W(CNT_W)) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en_v[g]),
                .cascade  (casc_v[g]),
                .sel      (tick_src_e'(src_sel)),
                .strobe   (cnt_strobe),
                .event_in (cnt_event),
                .capt     (capt_evt),
                .count    (cnt_v[g]),
                .cap      (cap_v[g]),
                .ovf      (ovf_v[g])
            );
        end else begin : g_chain
            cap_slice #(.W(CNT_W)) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en_v[g]),
                .cascade  (casc_v[g]),
                .sel      (SRC_EVENT),
                .strobe   (1'b0),
                .event_in (ovf_v[g-1]),
                .capt     (capt_evt),
                .count    (cnt_v[g]),
                .cap      (cap_v[g]),
                .ovf      (ovf_v[g])
            );
        end
    end

    assign cnt_lo    = cnt_v[0];
    assign cnt_hi    = cnt_v[1];
    assign ovf_lo    = ovf_v[0];
    assign ovf_hi    = ovf_v[1];
    assign cap_value = {cap_v[1], cap_v[0]};
endmodule

// File: rtl/cap_timer32_chk.sv
// Property checker for cap_timer32, attached with the bind below.
// Assumes: synchronous active-low reset; all checks are off while in reset.
module cap_timer32_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_lo,
    input logic           en_hi,
    input logic           casc_lo,
    input logic           casc_hi,
    input logic           capt_evt,
    input logic [W-1:0]   cnt_lo,
    input logic [W-1:0]   cnt_hi,
    input logic           ovf_lo,
    input logic [2*W-1:0] cap_value
);
    // Overflow is a single-cycle pulse.
    assert_ovf_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_lo |=> !ovf_lo);

    // An overflow pulse is seen only while the low count sits at zero.
    assert_ovf_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_lo |-> (cnt_lo == '0));

    // A disabled low slice keeps its count.
    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_lo |=> $stable(cnt_lo));

    // Each overflow pulse advances the high count by one.
    assert_hi_follows_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi && ovf_lo) |=> (cnt_hi == W'($past(cnt_hi) + 1'b1)));

    // Non-cascaded low capture takes the pre-edge count.
    assert_cap_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo && capt_evt && !casc_lo) |=> (cap_value[W-1:0] == $past(cnt_lo)));

    // Cascaded high capture takes the count one edge after the event.
    assert_cap_hi_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi && casc_hi && $past(rst_n && en_hi && capt_evt))
            |=> (cap_value[2*W-1:W] == $past(cnt_hi)));
endmodule

bind cap_timer32 cap_timer32_chk #(.W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_lo     (en_lo),
    .en_hi     (en_hi),
    .casc_lo   (casc_lo),
    .casc_hi   (casc_hi),
    .capt_evt  (capt_evt),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .ovf_lo    (ovf_lo),
    .cap_value (cap_value)
);

// File: tb/test_cap_timer32.sv
// Self-checking bench: sweeps capture phases on a 4-bit slice width.
module test_cap_timer32;
    localparam int W          = 4;
    localparam int M          = 1 << W;
    localparam int M2         = M * M;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n, en_lo, en_hi, casc_lo, casc_hi;
    logic [1:0]     src_sel;
    logic           cnt_strobe, cnt_event, capt_evt;
    logic [W-1:0]   cnt_lo, cnt_hi;
    logic           ovf_lo, ovf_hi;
    logic [2*W-1:0] cap_value;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model: total low ticks after the last edge, and one and two edges back.
    int n = 0, n_prev = 0;
    bit ovf_lo_e = 1'b0, ovf_hi_e = 1'b0;
    int exp_cap = 0, exp_lo = 0;

    cap_timer32 #(.CNT_W(W)) i_cap_timer32 (
        .clk(clk), .rst_n(rst_n), .en_lo(en_lo), .en_hi(en_hi),
        .casc_lo(casc_lo), .casc_hi(casc_hi), .src_sel(src_sel),
        .cnt_strobe(cnt_strobe), .cnt_event(cnt_event), .capt_evt(capt_evt),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi),
        .cap_value(cap_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check_state();
        check("R2 cnt_lo", int'(cnt_lo), n % M);
        check("R5 cnt_hi", int'(cnt_hi), (n_prev / M) % M);
        check("R3 ovf_lo", int'(ovf_lo), int'(ovf_lo_e));
        check("R10 ovf_hi", int'(ovf_hi), int'(ovf_hi_e));
    endtask

    // One clock: apply capture, update model at the edge, check at negedge.
    task automatic cyc(input logic c);
        bit tk;
        int n_old, n_prev_old;
        capt_evt = c;
        @(posedge clk);
        tk = en_lo && ((src_sel == 2'd0) || (src_sel == 2'd1 && cnt_strobe)
                       || (src_sel == 2'd2 && cnt_event));
        n_old      = n;
        n_prev_old = n_prev;
        if (c && en_lo && en_hi) begin
            exp_lo  = n_old % M;
            exp_cap = (casc_hi ? (n_old / M) % M : (n_prev_old / M) % M) * M + exp_lo;
        end
        ovf_hi_e = en_hi && ovf_lo_e && ((n_old % M2) == 0);
        ovf_lo_e = tk && (((n_old + 1) % M) == 0);
        n_prev   = n_old;
        n        = n_old + (tk ? 1 : 0);
        @(negedge clk);
        capt_evt = 1'b0;
        check_state();
    endtask

    task automatic capture_and_check(input string req);
        cyc(1'b1);
        cyc(1'b0);
        check({req, " cap_value"}, int'(cap_value), exp_cap);
        check("R6 low half", int'(cap_value[W-1:0]), exp_lo);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        n = 0; n_prev = 0; ovf_lo_e = 1'b0; ovf_hi_e = 1'b0;
        exp_cap = 0; exp_lo = 0;
        check("R1 cnt_lo", int'(cnt_lo), 0);
        check("R1 cnt_hi", int'(cnt_hi), 0);
        check("R1 cap_value", int'(cap_value), 0);
        check("R1 ovf", int'(ovf_lo) + int'(ovf_hi), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        rst_n = 1'b0; en_lo = 1'b1; en_hi = 1'b1; casc_lo = 1'b0; casc_hi = 1'b1;
        src_sel = 2'd0; cnt_strobe = 1'b0; cnt_event = 1'b0; capt_evt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        do_reset();

        // R7 sweep on the clock source, covering every low phase and a full wrap.
        for (int i = 0; i < 140; i++) begin
            capture_and_check("R7");
            if (i % 2 == 1) cyc(1'b0);
        end

        // R4 strobe source, with the unselected event line toggling.
        src_sel = 2'd1;
        for (int i = 0; i < 80; i++) begin
            cnt_strobe = (i % 3 != 0);
            cnt_event  = (i % 3 == 0);
            capture_and_check("R4 strobe R7");
        end

        // R4 event source, with the unselected strobe line toggling.
        src_sel = 2'd2;
        for (int i = 0; i < 80; i++) begin
            cnt_event  = (i % 2 == 0);
            cnt_strobe = (i % 2 != 0);
            capture_and_check("R4 event R7");
        end

        // R4 no source: nothing advances.
        src_sel = 2'd3;
        held = n;
        for (int i = 0; i < 6; i++) begin
            cnt_strobe = i[0]; cnt_event = ~i[0];
            cyc(1'b0);
        end
        check("R4 none held", n, held);
        cnt_strobe = 1'b0; cnt_event = 1'b0;

        // R9 high half captured at the event edge when cascade is cleared.
        src_sel = 2'd0;
        casc_hi = 1'b0;
        for (int i = 0; i < 60; i++) begin
            capture_and_check("R9");
            if (i % 2 == 0) cyc(1'b0);
        end
        casc_hi = 1'b1;
        cyc(1'b0);
        cyc(1'b0);

        // R8 disable with the low count at all ones: no wrap, no capture.
        while ((n % M) != M - 1) cyc(1'b0);
        en_lo = 1'b0; en_hi = 1'b0;
        held = int'(cap_value);
        for (int i = 0; i < 4; i++) cyc(1'b0);
        cyc(1'b1);
        cyc(1'b0);
        check("R8 cap_value unchanged", int'(cap_value), held);
        check("R8 cnt_lo held", int'(cnt_lo), M - 1);
        check("R8 no ovf", int'(ovf_lo), 0);
        en_lo = 1'b1; en_hi = 1'b1;
        for (int i = 0; i < 6; i++) capture_and_check("R8 resume R7");

        // R1 reset in the middle of counting.
        do_reset();
        for (int i = 0; i < 4; i++) capture_and_check("R1 after reset R7");

        finish_run();
    end
endmodule